// File: doc/BRIEF.md
# Quadrature Encoder Speed Meter

This block turns the two phase-shifted square waves of an incremental optical encoder into a signed speed figure. Channel A supplies the pulses and channel B, a quarter period away, tells the direction of rotation. A free-running window timer splits time into intervals of fixed length. During each interval an up/down counter adds one for every rising edge of A seen while B is low and subtracts one for every rising edge seen while B is high. At the end of each interval the count is copied into a speed register and the counter starts over from zero.

A host reads the latest speed, and reads or sets the interval length in clock cycles, through a small word-addressed register port. The latched speed is also available directly on an output pin. If an interval holds motion in both directions, the opposite pulses cancel and the reported figure lies between the two single-direction values.

Top module: `qenc_speed_meter`

## Requirements
- R1: Each of `enc_a` and `enc_b` passes through two synchronizing flops. A rising edge of `enc_a` that is present at clock edge k is added to the internal count at clock edge k+2.
- R2: A counted edge of A adds +1 when the synchronized B is 0 at that edge and adds -1 when it is 1. With a 4-cycle quadrature period and a 40-cycle interval, A leading B gives +10 and B leading A gives -10.
- R3: An interval boundary happens once every W cycles, where W is the window register. At a boundary `speed_o` takes the count of the interval that ends. Between boundaries `speed_o` holds its value.
- R4: The count is copied and cleared in the same cycle. An A edge that is counted in the boundary cycle starts the new interval's count at +1 or -1, so no pulse is lost.
- R5: The count is a 16-bit signed value. It saturates at +32767 and at -32768 instead of wrapping.
- R6: When an interval holds pulses in both directions, the reported speed equals the number of forward pulses minus the number of reverse pulses.
- R7: `bus_rdata` is registered and valid in the cycle after `bus_rd` is high. Reading offset 0 returns the speed, sign-extended to 32 bits. Reading offset 1 returns the window register. Reading offsets 2 and 3 returns 0.
- R8: Writing offset 1 sets the window length in cycles. Writes to the other offsets have no effect. After reset the window register holds 500000, which is 10 ms at a 50 MHz clock.
- R9: Synchronous active-high reset clears the synchronizers, the count, the speed register, the timer and the read data, and restores the default window.
- R10: A window value of 0 behaves as 1, so every cycle is a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| bus_addr | input | 2 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| speed_o | output | 16 | Latched signed speed of the last complete interval |

## Verification
The bench keeps its own cycle model of the synchronizers, the window and the saturating count, and compares it with `speed_o` in every cycle. Directed runs of one direction check that the figure is exactly +10 or -10. A design that took direction from the wrong phase would flip the sign, and one that cleared the counter a cycle late would drift to 9 or 11. Random runs with both directions mixed and several quadrature speeds place A edges exactly on the interval boundary. A design that dropped those edges, or counted them into the old interval, would differ from the model at the next boundary. Other runs shrink the window to zero, drive the count past +32767 so that a wrap would show up as a large negative number, read unmapped offsets, and reset in the middle of a run.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // Word offsets of the register port; the host software depends on these.
  typedef enum logic [1:0] {
    OFS_SPEED  = 2'd0,
    OFS_WINDOW = 2'd1,
    OFS_RSVD2  = 2'd2,
    OFS_RSVD3  = 2'd3
  } qenc_ofs_e;

  // Quotient of clock rate over one microsecond tick
  localparam int unsigned HZ_PER_MHZ = 1_000_000;

endpackage

// File: rtl/qenc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/qenc_window_timer.sv
// Free-running interval timer producing one boundary pulse per window.
module qenc_window_timer #(
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_tick,
  output logic [WIN_W-1:0] timer_q
);

  logic [WIN_W-1:0] eff_len;

  // A zero length would never match; treat it as a one-cycle window.
  assign eff_len  = (win_len == '0) ? WIN_W'(1) : win_len;
  assign win_tick = (timer_q >= (eff_len - WIN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
    end else if (win_tick) begin
      timer_q <= '0;
    end else begin
      timer_q <= timer_q + WIN_W'(1);
    end
  end

endmodule

// File: rtl/qenc_pulse_acc.sv
// Direction-aware saturating pulse counter with boundary latch.
module qenc_pulse_acc #(
  parameter int SPEED_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      a_sync,
  input  logic                      b_sync,
  input  logic                      win_tick,
  output logic                      a_rise,
  output logic signed [SPEED_W-1:0] cnt_q,
  output logic signed [SPEED_W-1:0] speed_q
);

  localparam logic signed [SPEED_W-1:0] SMAX = {1'b0, {(SPEED_W-1){1'b1}}};
  localparam logic signed [SPEED_W-1:0] SMIN = {1'b1, {(SPEED_W-1){1'b0}}};
  localparam logic signed [SPEED_W-1:0] ONE  = SPEED_W'(1);

  logic                      a_prev_q;
  logic signed [SPEED_W-1:0] base;
  logic signed [SPEED_W-1:0] cnt_d;

  assign a_rise = a_sync & ~a_prev_q;

  // At a boundary the new window starts from zero, plus any edge of this cycle.
  assign base = win_tick ? '0 : cnt_q;

  always_comb begin
    cnt_d = base;
    if (a_rise) begin
      if (b_sync) begin
        cnt_d = (base == SMIN) ? base : base - ONE;
      end else begin
        cnt_d = (base == SMAX) ? base : base + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev_q <= 1'b0;
      cnt_q    <= '0;
      speed_q  <= '0;
    end else begin
      a_prev_q <= a_sync;
      cnt_q    <= cnt_d;
      if (win_tick) begin
        speed_q <= cnt_q;
      end
    end
  end

endmodule

// File: rtl/qenc_bus_regs.sv
// Word-addressed register port: speed readback and window length.
module qenc_bus_regs
  import qenc_pkg::*;
#(
  parameter int                ADDR_W  = 2,
  parameter int                DATA_W  = 32,
  parameter int                SPEED_W = 16,
  parameter int                WIN_W   = 32,
  parameter logic [WIN_W-1:0]  WIN_RST = WIN_W'(500000)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic signed [SPEED_W-1:0] speed_i,
  output logic [WIN_W-1:0]          win_len
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      OFS_SPEED:  rd_mux = {{(DATA_W-SPEED_W){speed_i[SPEED_W-1]}}, speed_i};
      OFS_WINDOW: rd_mux = DATA_W'(win_len);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_len   <= WIN_RST;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFS_WINDOW)) begin
        win_len <= bus_wdata[WIN_W-1:0];
      end
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/qenc_speed_meter.sv
// Top: encoder synchronizers, window timer, pulse counter, register port.
module qenc_speed_meter
  import qenc_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int WINDOW_US = 10_000,
  parameter int SPEED_W   = 16,
  parameter int WIN_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int SYNC_N    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enc_a,
  input  logic                      enc_b,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic signed [SPEED_W-1:0] speed_o
);

  localparam longint          WIN_CYC = longint'(CLK_HZ) / longint'(HZ_PER_MHZ) * longint'(WINDOW_US);
  localparam logic [WIN_W-1:0] WIN_RST = WIN_W'(WIN_CYC);

  logic [1:0]                enc_sync;
  logic                      win_tick;
  logic [WIN_W-1:0]          timer_q;
  logic [WIN_W-1:0]          win_len;
  logic                      a_rise;
  logic signed [SPEED_W-1:0] pulse_cnt;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({enc_b, enc_a}),
    .sync_o  (enc_sync)
  );

  qenc_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .win_len  (win_len),
    .win_tick (win_tick),
    .timer_q  (timer_q)
  );

  qenc_pulse_acc #(.SPEED_W(SPEED_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .a_sync   (enc_sync[0]),
    .b_sync   (enc_sync[1]),
    .win_tick (win_tick),
    .a_rise   (a_rise),
    .cnt_q    (pulse_cnt),
    .speed_q  (speed_o)
  );

  qenc_bus_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SPEED_W (SPEED_W),
    .WIN_W   (WIN_W),
    .WIN_RST (WIN_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .speed_i   (speed_o),
    .win_len   (win_len)
  );

endmodule

// File: rtl/qenc_speed_meter_chk.sv
// Property checker attached to the top module.
module qenc_speed_meter_chk #(
  parameter int SPEED_W = 16,
  parameter int WIN_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      win_tick,
  input logic                      a_rise,
  input logic [WIN_W-1:0]          timer_q,
  input logic signed [SPEED_W-1:0] pulse_cnt,
  input logic signed [SPEED_W-1:0] speed_o,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_rdata
);

  localparam logic signed [SPEED_W-1:0] SMAX = {1'b0, {(SPEED_W-1){1'b1}}};
  localparam logic signed [SPEED_W-1:0] SMIN = {1'b1, {(SPEED_W-1){1'b0}}};

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !win_tick |=> $stable(speed_o));

  assert_latch_R3: assert property (@(posedge clk) disable iff (rst)
    win_tick |=> (speed_o == $past(pulse_cnt)));

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    win_tick |=> (timer_q == '0));

  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (win_tick && a_rise) |=> ((pulse_cnt == SPEED_W'(1)) || (pulse_cnt == -SPEED_W'(1))));

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!win_tick && !a_rise) |=> $stable(pulse_cnt));

  assert_no_wrap_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (!win_tick && pulse_cnt == SMAX) |=> (pulse_cnt != SMIN));

  assert_no_wrap_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (!win_tick && pulse_cnt == SMIN) |=> (pulse_cnt != SMAX));

  assert_rd_speed_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0)) |=>
      (bus_rdata == {{(DATA_W-SPEED_W){$past(speed_o[SPEED_W-1])}}, $past(speed_o)}));

  assert_rd_rsvd_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= ADDR_W'(2)) |=> (bus_rdata == '0));

endmodule

bind qenc_speed_meter qenc_speed_meter_chk #(
  .SPEED_W (SPEED_W),
  .WIN_W   (WIN_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win_tick  (win_tick),
  .a_rise    (a_rise),
  .timer_q   (timer_q),
  .pulse_cnt (pulse_cnt),
  .speed_o   (speed_o),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/qenc_speed_meter_tb.sv
module qenc_speed_meter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_DEF    = 500000;
  localparam int SMAX       = 32767;
  localparam int SMIN       = -32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic signed [15:0] speed_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_speed_meter u_dut (
    .clk       (clk),
    .rst       (rst),
    .enc_a     (enc_a),
    .enc_b     (enc_b),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .speed_o   (speed_o)
  );

  function automatic int sat_step(input int v, input bit down);
    if (down) return (v == SMIN) ? v : v - 1;
    return (v == SMAX) ? v : v + 1;
  endfunction

  function automatic int sext16(input int v);
    return v;  // model speeds are already held as signed integers
  endfunction

  function automatic int rd_expect(input int ofs, input int spd, input int win);
    if (ofs == 0) return sext16(spd);
    if (ofs == 1) return win;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model, built from the requirements
  bit m_a0, m_a1, m_ap, m_b0, m_b1;
  int m_cnt, m_speed, m_timer, m_win;
  int m_rdata;
  bit m_rd_valid, m_edge_tick;

  always @(posedge clk) begin
    int eff;
    bit tick, rise;
    if (rst) begin
      {m_a0, m_a1, m_ap, m_b0, m_b1} = '0;
      m_cnt = 0; m_speed = 0; m_timer = 0; m_win = WIN_DEF;
      m_rdata = 0; m_rd_valid = 1'b1; m_edge_tick = 1'b0;
    end else begin
      eff  = (m_win == 0) ? 1 : m_win;
      tick = (m_timer >= eff - 1);
      rise = m_a1 & ~m_ap;
      m_rd_valid = bus_rd;
      if (bus_rd) m_rdata = rd_expect(int'(bus_addr), m_speed, m_win);
      if (tick) begin
        m_speed = m_cnt;
        m_cnt = rise ? sat_step(0, m_b1) : 0;
        m_timer = 0;
        if (rise) m_edge_tick = 1'b1;
      end else begin
        if (rise) m_cnt = sat_step(m_cnt, m_b1);
        m_timer++;
      end
      if (bus_wr && bus_addr == 2'd1) m_win = int'(bus_wdata);
      m_ap = m_a1; m_a1 = m_a0; m_a0 = enc_a;
      m_b1 = m_b0; m_b0 = enc_b;
    end
  end

  // Continuous comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(m_edge_tick ? "R4" : tag, int'(speed_o), m_speed);
    if (m_rd_valid) check("R7", int'(bus_rdata), m_rdata);
  end

  always @(negedge clk) begin
    if (cycles > 180000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<180000", cycles);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input int ofs, input int data);
    bus_addr = 2'(ofs); bus_wdata = 32'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int ofs, output int data);
    bus_addr = 2'(ofs); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  // One quadrature period; dir 0: A leads (B low at A rise), dir 1: B leads.
  task automatic quad(input bit dir, input int q, input int n);
    for (int p = 0; p < n; p++) begin
      for (int s = 0; s < 4; s++) begin
        case (s)
          0: begin enc_a = 1'b0; enc_b = 1'b0; end
          1: begin enc_a = !dir; enc_b = dir;  end
          2: begin enc_a = 1'b1; enc_b = 1'b1; end
          default: begin enc_a = dir; enc_b = !dir; end
        endcase
        idle(q);
      end
    end
  endtask

  initial begin
    int rv;
    rv = int'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    idle(1);

    // Reset state
    check("R9", int'(speed_o), 0);
    bus_read(1, rv); check("R8", rv, WIN_DEF);
    bus_read(0, rv); check("R9", rv, 0);
    bus_read(2, rv); check("R7", rv, 0);

    // Window register; writes elsewhere ignored
    bus_write(0, 123);
    bus_write(3, 77);
    bus_read(1, rv); check("R8", rv, WIN_DEF);
    bus_write(1, 40);
    bus_read(1, rv); check("R8", rv, 40);

    // Single direction, exact figures
    tag = "R2";
    quad(1'b0, 1, 30);
    check("R2", int'(speed_o), 10);
    bus_read(0, rv); check("R7", rv, 10);
    quad(1'b1, 1, 30);
    check("R2", int'(speed_o), -10);
    bus_read(0, rv); check("R7", rv, -10);

    // Latency of a single edge: one pulse, then quiet
    tag = "R1";
    enc_a = 1'b0; enc_b = 1'b0;
    idle(90);
    enc_a = 1'b1;
    idle(90);
    check("R1", int'(speed_o), 0);
    enc_a = 1'b0;

    // Mixed directions, random speeds, odd window to move edges across boundaries
    tag = "R6";
    bus_write(1, 37);
    for (int i = 0; i < 60; i++) begin
      quad(1'($urandom % 2), 1 + int'($urandom % 3), 1 + int'($urandom % 6));
      if ($urandom % 4 == 0) begin
        bus_read(int'($urandom % 4), rv);
      end
    end

    // Boundary every cycle
    tag = "R10";
    bus_write(1, 0);
    quad(1'b0, 1, 5);
    quad(1'b1, 2, 5);
    bus_write(1, 1);
    quad(1'b0, 1, 3);

    // Reset during activity
    tag = "R9";
    bus_write(1, 20);
    quad(1'b0, 1, 12);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    check("R9", int'(speed_o), 0);
    bus_read(1, rv); check("R9", rv, WIN_DEF);

    // Saturation at the positive limit
    tag = "R5";
    bus_write(1, 70000);
    enc_b = 1'b0;
    for (int i = 0; i < 33000; i++) begin
      enc_a = 1'b1; idle(1);
      enc_a = 1'b0; idle(1);
    end
    for (int i = 0; i < 6000 && int'(speed_o) == 0; i++) idle(1);
    check("R5", int'(speed_o), SMAX);
    bus_read(0, rv); check("R5", rv, SMAX);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule